// File: doc/BRIEF.md
# Receive Flow Sequence Checker

This block holds a table of per-flow receive state for expected-data packets. Every entry carries the next sequence number the flow expects, the generation the flow is currently running, a valid bit, four policy bits and two sticky mismatch status bits. When a packet arrives with its flow index, generation and sequence number, the block decides whether the payload is placed, whether software receives a header entry, and which mismatch was seen. A clean match moves the flow's expected sequence number on by one.

Software programs an entry by writing a whole 64-bit word and reads it back through the same small port. A flow can be parked by giving it the all-ones generation, which no real packet carries. With both generation-error keep bits clear, every packet to such a flow then loses its payload and its header. The decision for each accepted packet appears exactly one clock after acceptance, so a stream of packets can be checked at one per clock.

Top module: `rx_flow_seq_check`

## Requirements
- R1: An entry is a 64-bit word with this layout: expected sequence in bits 10:0, generation in bits 30:11, flow valid in bit 32, header suppress in bit 33, keep header after sequence error in bit 34, keep header on generation error in bit 35, keep payload on generation error in bit 36, sequence mismatch status in bit 37, generation mismatch status in bit 38. Bits 31 and 63:39 read as zero. A read asserted in one cycle returns the entry in `sw_rdata` with `sw_rd_valid` high in the next cycle. After reset every entry reads as zero.
- R2: A software write replaces every field of the addressed entry, including both status bits. `pkt_ready` is low in every cycle in which `sw_wr_en` is high.
- R3: Each packet accepted (`pkt_valid` and `pkt_ready` high at a clock edge) produces exactly one `dec_valid` pulse, in the cycle after acceptance. Back-to-back packets to one flow see the state left by the previous packet.
- R4: On a valid flow where the generation and the sequence both match, the payload is delivered. A header is produced only when header suppress is 0. The expected sequence increments modulo 2048, so 0x7FF wraps to 0.
- R5: On a valid flow whose generation differs from the packet's, `dec_gen_err` is set and `dec_seq_err` is not. Payload delivery follows keep-payload-on-generation-error and header production follows keep-header-on-generation-error. The generation mismatch status bit is set and the sequence is unchanged.
- R6: On a valid flow whose generation matches but whose sequence differs, `dec_seq_err` is set and the payload is dropped. A header is produced only when keep-header-after-sequence-error is 1. The sequence mismatch status bit is set and the sequence is unchanged.
- R7: A packet to a flow whose valid bit is 0 is dropped with no header and no error flags, and the entry is left unchanged.
- R8: Status bits, once set, stay set through later matching packets until a software write clears them.
- R9: A flow parked with valid 1, generation 0xFFFFF, sequence 0x7FF and all policy bits 0 drops payload and header for any packet with another generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Packet check request |
| pkt_ready | output | 1 | Block can accept a packet this cycle |
| pkt_flow | input | IDX_W | Flow index of the packet |
| pkt_gen | input | 20 | Packet generation |
| pkt_seq | input | 11 | Packet sequence number |
| dec_valid | output | 1 | Decision valid, one cycle after acceptance |
| dec_deliver | output | 1 | Payload is to be placed |
| dec_header | output | 1 | Header entry is to be produced |
| dec_seq_err | output | 1 | Sequence mismatch seen |
| dec_gen_err | output | 1 | Generation mismatch seen |
| sw_wr_en | input | 1 | Software write strobe |
| sw_rd_en | input | 1 | Software read strobe |
| sw_addr | input | IDX_W | Entry index for read or write |
| sw_wdata | input | 64 | Entry word to write |
| sw_rd_valid | output | 1 | Read data valid |
| sw_rdata | output | 64 | Entry word read |

## Verification
On every cycle the assertions check the one-cycle decision latency and that no decision appears without an accepted packet. They also check that writes hold off packets, that read data follows a read strobe, that a generation error never reports a sequence error alongside it, that a sequence error never delivers payload, and that a status bit only clears on a write to its own entry. The actual policy outcomes can only be shown by the bench's scenarios: which keep bit governs which output, the sequence increment and its wrap at 0x7FF, the untouched entry after a mismatch or an invalid flow, and the parked-flow behaviour.

// File: rtl/rfsc_pkg.sv
// Package: shared entry type and word packing for the flow sequence checker.
// Assumes: the 64-bit software word layout is fixed; only the table depth varies.
package rfsc_pkg;
    localparam int SEQ_W  = 11;
    localparam int GEN_W  = 20;
    localparam int WORD_W = 64;

    // One flow entry; the field order here is internal, the word layout is in the functions.
    typedef struct packed {
        logic             gen_mm;
        logic             seq_mm;
        logic             keep_pay_gerr;
        logic             keep_hdr_gerr;
        logic             keep_hdr_serr;
        logic             hdr_supp;
        logic             valid;
        logic [GEN_W-1:0] gen;
        logic [SEQ_W-1:0] seq;
    } flow_ent_t;

    localparam int ENT_W = $bits(flow_ent_t);

    // Pack an entry into the software-visible word; undefined bits are zero.
    function automatic logic [WORD_W-1:0] ent_to_word(flow_ent_t e);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[10:0]    = e.seq;
        w[30:11]   = e.gen;
        w[32]      = e.valid;
        w[33]      = e.hdr_supp;
        w[34]      = e.keep_hdr_serr;
        w[35]      = e.keep_hdr_gerr;
        w[36]      = e.keep_pay_gerr;
        w[37]      = e.seq_mm;
        w[38]      = e.gen_mm;
        return w;
    endfunction

    // Unpack a software word into an entry; undefined bits are discarded.
    function automatic flow_ent_t word_to_ent(logic [WORD_W-1:0] w);
        flow_ent_t e;
        e.seq           = w[10:0];
        e.gen           = w[30:11];
        e.valid         = w[32];
        e.hdr_supp      = w[33];
        e.keep_hdr_serr = w[34];
        e.keep_hdr_gerr = w[35];
        e.keep_pay_gerr = w[36];
        e.seq_mm        = w[37];
        e.gen_mm        = w[38];
        return e;
    endfunction
endpackage

// File: rtl/rfsc_flow_table.sv
// Flow table: DEPTH entries in flops, one software write port, one packet
// update port, one combinational lookup for the packet path and one
// registered read for software.
// Assumes: the top never raises wr_en and upd_en in the same cycle; if it
// did, the software write would win.
module rfsc_flow_table
    import rfsc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  flow_ent_t        wr_ent,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  flow_ent_t        upd_ent,
    input  logic [IDX_W-1:0] look_idx,
    output flow_ent_t        look_ent,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output flow_ent_t        rd_ent
);
    flow_ent_t ent_q [DEPTH];

    // Entry storage: software write has priority over the packet update.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q[i] <= wr_ent;
            end else if (upd_en && (upd_idx == IDX_W'(i))) begin
                ent_q[i] <= upd_ent;
            end
        end
    end

    // Packet-path lookup of the addressed entry.
    assign look_ent = ent_q[look_idx];

    // Software read: capture the entry one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_ent   <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_ent <= ent_q[rd_idx];
            end
        end
    end

    // Per-entry checks: status bits only clear through a write to that entry.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_sticky
            AST_SEQ_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ent_q[g].seq_mm) |-> $past(wr_en && (wr_idx == IDX_W'(g)))); // R8
            AST_GEN_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ent_q[g].gen_mm) |-> $past(wr_en && (wr_idx == IDX_W'(g)))); // R8
        end
    endgenerate
endmodule

// File: rtl/rfsc_judge.sv
// Judge: purely combinational check of one packet against one entry.
// Produces the payload/header decision, error flags and the entry to write back.
// Assumes: the entry given is the current one for the packet's flow.
module rfsc_judge
    import rfsc_pkg::*;
(
    input  flow_ent_t        ent,
    input  logic [GEN_W-1:0] pkt_gen,
    input  logic [SEQ_W-1:0] pkt_seq,
    output logic             deliver,
    output logic             header,
    output logic             seq_err,
    output logic             gen_err,
    output logic             write_back,
    output flow_ent_t        nxt_ent
);
    logic gen_ok;
    logic seq_ok;

    assign gen_ok = (pkt_gen == ent.gen);
    assign seq_ok = (pkt_seq == ent.seq);

    // Decision: generation is checked first; sequence only on a matching generation.
    always_comb begin
        nxt_ent    = ent;
        deliver    = 1'b0;
        header     = 1'b0;
        seq_err    = 1'b0;
        gen_err    = 1'b0;
        write_back = 1'b0;
        if (ent.valid) begin
            write_back = 1'b1;
            if (!gen_ok) begin
                gen_err        = 1'b1;
                deliver        = ent.keep_pay_gerr;
                header         = ent.keep_hdr_gerr;
                nxt_ent.gen_mm = 1'b1;
            end else if (!seq_ok) begin
                seq_err        = 1'b1;
                header         = ent.keep_hdr_serr;
                nxt_ent.seq_mm = 1'b1;
            end else begin
                deliver     = 1'b1;
                header      = !ent.hdr_supp;
                nxt_ent.seq = ent.seq + SEQ_W'(1);
            end
        end
    end
endmodule

// File: rtl/rx_flow_seq_check.sv
// Receive flow sequence checker top: accepts one packet per cycle unless a
// software write is in progress, judges it against its flow entry, writes
// the entry back and registers the decision for one cycle.
// Assumes: pkt_flow and sw_addr are below DEPTH.
module rx_flow_seq_check
    import rfsc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [IDX_W-1:0]  pkt_flow,
    input  logic [19:0]       pkt_gen,
    input  logic [10:0]       pkt_seq,
    output logic              dec_valid,
    output logic              dec_deliver,
    output logic              dec_header,
    output logic              dec_seq_err,
    output logic              dec_gen_err,
    input  logic              sw_wr_en,
    input  logic              sw_rd_en,
    input  logic [IDX_W-1:0]  sw_addr,
    input  logic [63:0]       sw_wdata,
    output logic              sw_rd_valid,
    output logic [63:0]       sw_rdata
);
    logic      accept;
    flow_ent_t look_ent;
    flow_ent_t nxt_ent;
    flow_ent_t rd_ent;
    logic      j_deliver;
    logic      j_header;
    logic      j_seq_err;
    logic      j_gen_err;
    logic      j_wb;

    // Software writes take the table for the cycle; packets wait.
    assign pkt_ready = !sw_wr_en;
    assign accept    = pkt_valid && pkt_ready;

    rfsc_flow_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sw_wr_en),
        .wr_idx   (sw_addr),
        .wr_ent   (word_to_ent(sw_wdata)),
        .upd_en   (accept && j_wb),
        .upd_idx  (pkt_flow),
        .upd_ent  (nxt_ent),
        .look_idx (pkt_flow),
        .look_ent (look_ent),
        .rd_en    (sw_rd_en),
        .rd_idx   (sw_addr),
        .rd_valid (sw_rd_valid),
        .rd_ent   (rd_ent)
    );

    rfsc_judge u_judge (
        .ent        (look_ent),
        .pkt_gen    (pkt_gen),
        .pkt_seq    (pkt_seq),
        .deliver    (j_deliver),
        .header     (j_header),
        .seq_err    (j_seq_err),
        .gen_err    (j_gen_err),
        .write_back (j_wb),
        .nxt_ent    (nxt_ent)
    );

    assign sw_rdata = ent_to_word(rd_ent);

    // Decision register: one pulse per accepted packet, flags zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid   <= 1'b0;
            dec_deliver <= 1'b0;
            dec_header  <= 1'b0;
            dec_seq_err <= 1'b0;
            dec_gen_err <= 1'b0;
        end else begin
            dec_valid   <= accept;
            dec_deliver <= accept && j_deliver;
            dec_header  <= accept && j_header;
            dec_seq_err <= accept && j_seq_err;
            dec_gen_err <= accept && j_gen_err;
        end
    end

    AST_DEC_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> dec_valid); // R3
    AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && pkt_ready) |=> !dec_valid); // R3
    AST_WRITE_HOLDS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |-> !pkt_ready); // R2
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rd_en |=> sw_rd_valid); // R1
    AST_GEN_MASKS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(dec_gen_err && dec_seq_err)); // R5
    AST_SEQERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_seq_err) |-> !dec_deliver); // R6
endmodule

// File: tb/test_rx_flow_seq_check.sv
module test_rx_flow_seq_check;
    localparam int DEPTH = 32;
    localparam int IDX_W = 5;
    localparam logic [63:0] DEF_MASK = 64'h0000_007F_7FFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0;
    logic pkt_ready;
    logic [IDX_W-1:0] pkt_flow = '0;
    logic [19:0] pkt_gen = '0;
    logic [10:0] pkt_seq = '0;
    logic dec_valid, dec_deliver, dec_header, dec_seq_err, dec_gen_err;
    logic sw_wr_en = 1'b0;
    logic sw_rd_en = 1'b0;
    logic [IDX_W-1:0] sw_addr = '0;
    logic [63:0] sw_wdata = '0;
    logic sw_rd_valid;
    logic [63:0] sw_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rx_flow_seq_check #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_rx_flow_seq_check (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_flow(pkt_flow),
        .pkt_gen(pkt_gen), .pkt_seq(pkt_seq),
        .dec_valid(dec_valid), .dec_deliver(dec_deliver), .dec_header(dec_header),
        .dec_seq_err(dec_seq_err), .dec_gen_err(dec_gen_err),
        .sw_wr_en(sw_wr_en), .sw_rd_en(sw_rd_en), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rd_valid(sw_rd_valid), .sw_rdata(sw_rdata)
    );

    // Build a word from fields following the layout in R1.
    function automatic logic [63:0] mk(input logic [10:0] seq, input logic [19:0] gen,
                                       input bit vld, input bit supp, input bit kas,
                                       input bit khg, input bit kpg, input bit sm, input bit gm);
        logic [63:0] w = '0;
        w[10:0] = seq; w[30:11] = gen; w[32] = vld; w[33] = supp; w[34] = kas;
        w[35] = khg; w[36] = kpg; w[37] = sm; w[38] = gm;
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [IDX_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_addr = a; sw_wdata = d;
        @(posedge clk);
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic sw_read(input logic [IDX_W-1:0] a, output logic [63:0] d);
        @(negedge clk);
        sw_rd_en = 1'b1; sw_addr = a;
        @(posedge clk);
        @(negedge clk);
        check("R1 rd_valid", {63'b0, sw_rd_valid}, 64'd1);
        d = sw_rdata;
        sw_rd_en = 1'b0;
    endtask

    // Send one packet; returns {deliver, header, seq_err, gen_err} sampled one cycle later.
    task automatic send(input logic [IDX_W-1:0] f, input logic [19:0] g, input logic [10:0] s,
                        output logic [3:0] r);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_flow = f; pkt_gen = g; pkt_seq = s;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        check("R3 dec_valid", {63'b0, dec_valid}, 64'd1);
        r = {dec_deliver, dec_header, dec_seq_err, dec_gen_err};
    endtask

    task automatic t_reset;
        logic [63:0] d;
        check("R1 reset dec_valid", {63'b0, dec_valid}, 64'd0);
        check("R2 reset ready", {63'b0, pkt_ready}, 64'd1);
        sw_read(5'd9, d);
        check("R1 reset entry", d, 64'd0);
    endtask

    task automatic t_layout;
        logic [63:0] d;
        logic [63:0] w = 64'hA5A5_A5F5_DEAD_BEEF;
        @(negedge clk);
        sw_wr_en = 1'b1; sw_addr = 5'd3; sw_wdata = w;
        #1 check("R2 ready low on write", {63'b0, pkt_ready}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        sw_wr_en = 1'b0;
        sw_read(5'd3, d);
        check("R1 layout readback", d, w & DEF_MASK);
        sw_write(5'd3, mk(11'd1, 20'd2, 1, 0, 0, 0, 0, 0, 0));
        sw_read(5'd3, d);
        check("R2 whole entry replaced", d, mk(11'd1, 20'd2, 1, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_match;
        logic [3:0] r;
        logic [63:0] d;
        sw_write(5'd5, mk(11'd10, 20'h12345, 1, 0, 0, 0, 0, 0, 0));
        send(5'd5, 20'h12345, 11'd10, r);
        check("R4 match deliver+header", {60'b0, r}, 64'b1100);
        sw_read(5'd5, d);
        check("R4 seq advanced", d, mk(11'd11, 20'h12345, 1, 0, 0, 0, 0, 0, 0));
        sw_write(5'd5, mk(11'h7FF, 20'h12345, 1, 1, 0, 0, 0, 0, 0));
        send(5'd5, 20'h12345, 11'h7FF, r);
        check("R4 suppressed header", {60'b0, r}, 64'b1000);
        sw_read(5'd5, d);
        check("R4 seq wraps", d, mk(11'd0, 20'h12345, 1, 1, 0, 0, 0, 0, 0));
    endtask

    task automatic t_back_to_back;
        logic [3:0] r1, r2;
        sw_write(5'd12, mk(11'd100, 20'h7, 1, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        pkt_valid = 1'b1; pkt_flow = 5'd12; pkt_gen = 20'h7; pkt_seq = 11'd100;
        @(posedge clk);
        @(negedge clk);
        r1 = {dec_deliver, dec_header, dec_seq_err, dec_gen_err};
        check("R3 first dec_valid", {63'b0, dec_valid}, 64'd1);
        pkt_seq = 11'd101;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        r2 = {dec_deliver, dec_header, dec_seq_err, dec_gen_err};
        check("R3 second dec_valid", {63'b0, dec_valid}, 64'd1);
        check("R3 first decision", {60'b0, r1}, 64'b1100);
        check("R3 second sees update", {60'b0, r2}, 64'b1100);
        @(posedge clk);
        @(negedge clk);
        check("R3 idle no dec", {63'b0, dec_valid}, 64'd0);
    endtask

    task automatic t_generr;
        logic [3:0] r;
        logic [63:0] d;
        sw_write(5'd6, mk(11'd4, 20'hAAAA, 1, 0, 0, 0, 1, 0, 0));
        send(5'd6, 20'hBBBB, 11'd9, r);
        check("R5 keep payload only", {60'b0, r}, 64'b1001);
        sw_read(5'd6, d);
        check("R5 gen status, seq kept", d, mk(11'd4, 20'hAAAA, 1, 0, 0, 0, 1, 0, 1));
        sw_write(5'd6, mk(11'd4, 20'hAAAA, 1, 0, 0, 1, 0, 0, 0));
        send(5'd6, 20'hBBBB, 11'd4, r);
        check("R5 keep header only", {60'b0, r}, 64'b0101);
    endtask

    task automatic t_seqerr;
        logic [3:0] r;
        logic [63:0] d;
        sw_write(5'd7, mk(11'd20, 20'h55, 1, 0, 1, 0, 0, 0, 0));
        send(5'd7, 20'h55, 11'd22, r);
        check("R6 header kept on seq err", {60'b0, r}, 64'b0110);
        sw_read(5'd7, d);
        check("R6 seq status, seq kept", d, mk(11'd20, 20'h55, 1, 0, 1, 0, 0, 1, 0));
        send(5'd7, 20'h55, 11'd20, r);
        check("R8 clean after err", {60'b0, r}, 64'b1100);
        sw_read(5'd7, d);
        check("R8 status stays set", d, mk(11'd21, 20'h55, 1, 0, 1, 0, 0, 1, 0));
        sw_write(5'd7, mk(11'd21, 20'h55, 1, 0, 0, 0, 0, 0, 0));
        sw_read(5'd7, d);
        check("R8 write clears status", d, mk(11'd21, 20'h55, 1, 0, 0, 0, 0, 0, 0));
        send(5'd7, 20'h55, 11'd0, r);
        check("R6 no header without keep", {60'b0, r}, 64'b0010);
    endtask

    task automatic t_invalid;
        logic [3:0] r;
        logic [63:0] d;
        sw_write(5'd8, mk(11'd2, 20'h9, 0, 0, 1, 1, 1, 0, 0));
        send(5'd8, 20'h9, 11'd2, r);
        check("R7 invalid matching pkt", {60'b0, r}, 64'b0000);
        send(5'd8, 20'h3, 11'd5, r);
        check("R7 invalid mismatching pkt", {60'b0, r}, 64'b0000);
        sw_read(5'd8, d);
        check("R7 entry unchanged", d, mk(11'd2, 20'h9, 1'b0, 0, 1, 1, 1, 0, 0));
    endtask

    task automatic t_reserved;
        logic [3:0] r;
        logic [63:0] d;
        sw_write(5'd31, mk(11'h7FF, 20'hFFFFF, 1, 0, 0, 0, 0, 0, 0));
        send(5'd31, 20'h00001, 11'h7FF, r);
        check("R9 parked drops all", {60'b0, r}, 64'b0001);
        send(5'd31, 20'hFFFFE, 11'd0, r);
        check("R9 parked drops other gen", {60'b0, r}, 64'b0001);
        sw_read(5'd31, d);
        check("R9 parked entry", d, mk(11'h7FF, 20'hFFFFF, 1, 0, 0, 0, 0, 0, 1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_match();
        t_back_to_back();
        t_generr();
        t_seqerr();
        t_invalid();
        t_reserved();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule